// File: doc/BRIEF.md
# Cascaded Pattern-Pacing Timer

This block paces digital pattern generation for two port groups. It holds three 16-bit divide-by-N counters. The first counter is a free-running prescaler clocked by a fixed base tick, nominally 2 MHz. Its terminal strobe raises a one-cycle interrupt pulse once per period, and it can also serve as the clock of either request counter. The other two counters generate handshake requests, one for each group. Each request counter runs only while its configuration enable bit and its external active-high enable pin are both high.

A per-group handshake-select bit decides what drives that group's request line: the request counter's square wave, or the group's external request input passed straight through. Software programs the block through a plain write port that carries three reload registers and one configuration register. Every counting source inside the block is a one-cycle enable strobe on the single system clock. No derived clocks are used.

All pins are plain control and status signals. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `pgt_top`

## Requirements
- R1: With the base tick held high, the prescaler raises `irq` for exactly one cycle once every N base ticks, where N is the decoded prescaler reload.
- R2: A reload value of 0 decodes to N = 65536, and a reload value of 1 decodes to N = 2. Any other value v decodes to N = v.
- R3: Each counter makes a square wave of period N input ticks. The output is high for the first ceil(N/2) ticks of each period and low for the remaining floor(N/2) ticks.
- R4: Request counter k (k = 1, 2) is gated on only when configuration bit k-1 is 1 and `ext_en[k-1]` is high. While gated off, its output is low and its count returns to the start of a period.
- R5: Configuration bit 4 (counter 1) and bit 5 (counter 2) select the clock source of the request counter. A value of 0 selects `base_tick`, and a value of 1 selects the prescaler's terminal strobe.
- R6: Configuration bit 2 (group 1) and bit 3 (group 2) select what drives the request line. When the bit is 1, `req[k-1]` is the counter output. When the bit is 0, `req[k-1]` equals `ext_req[k-1]`.
- R7: A write to a reload register restarts that counter at the start of a period on its next input tick, using the new value.
- R8: The write address map is: 0 = prescaler reload, 1 = request counter 1 reload, 2 = request counter 2 reload, 3 = configuration (data bits 5:0). All registers clear to 0 on reset.
- R9: After reset, `irq` is low and each `req` line equals its `ext_req` input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle strobe of the base timebase (nominally 2 MHz) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| ext_en | input | 2 | External active-high enables for request counters 1 and 2 |
| ext_req | input | 2 | External handshake requests for groups 1 and 2 |
| req | output | 2 | Group request lines |
| irq | output | 1 | One-cycle interrupt pulse at each prescaler period |

## Verification
The assertions check these properties on every cycle:
- a gated-off counter drives a low output;
- the count stays within the decoded period unless a restart is pending;
- a terminal count or a pending restart returns the count to zero;
- `irq` never lasts longer than one cycle;
- the configuration register changes only on a write to its address.

Only the bench scenarios can show the behaviours that play out over many cycles:
- the duty split of odd and even periods;
- the decoding of reload values 0 and 1 into real periods;
- the change of rate when a request counter is cascaded from the prescaler;
- the exact restart pattern after a reload write;
- the pass-through of external requests.

A cycle-level reference model in the bench is compared with both request lines and the interrupt throughout random register traffic.

// File: rtl/pgt_pkg.sv
package pgt_pkg;
  localparam int CNT_W     = 16;
  localparam int ADDR_W    = 2;
  localparam int NUM_GRP   = 2;
  localparam int NUM_DIV   = NUM_GRP + 1;
  localparam int CFG_W     = 6;
  localparam int CFG_EN_LSB  = 0;
  localparam int CFG_HS_LSB  = 2;
  localparam int CFG_SRC_LSB = 4;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd3;
endpackage

// File: rtl/pgt_regs.sv
module pgt_regs
  import pgt_pkg::*;
#(
  parameter int CW   = CNT_W,
  parameter int AW   = ADDR_W,
  parameter int ND   = NUM_DIV,
  parameter int CFGW = CFG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [CW-1:0]         wr_data,
  output logic [ND-1:0][CW-1:0] reload_q,
  output logic [ND-1:0]         load_stb,
  output logic [CFGW-1:0]       cfg_q
);
  logic cfg_wr;
  assign cfg_wr = wr_en && (wr_addr == ADDR_CFG);

  // One reload register per divider; address i selects divider i.
  for (genvar i = 0; i < ND; i++) begin : g_rel
    assign load_stb[i] = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)           reload_q[i] <= '0;
      else if (load_stb[i]) reload_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= wr_data[CFGW-1:0];
  end

  // R8: configuration changes only through its own address
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q));
endmodule

// File: rtl/pgt_divider.sv
module pgt_divider #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gate,
  input  logic          load_stb,
  input  logic [CW-1:0] reload,
  output logic          out,
  output logic          term
);
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};
  localparam logic [CW:0] ONE  = {{CW{1'b0}}, 1'b1};
  localparam logic [CW:0] TWO  = {{(CW-1){1'b0}}, 2'b10};

  logic [CW:0]   n_eff;
  logic [CW:0]   hi_len;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          last;

  // Reload decode: 0 means full range, 1 is held at 2.
  always_comb begin
    if (reload == '0)               n_eff = FULL;
    else if (reload == CW'(1))      n_eff = TWO;
    else                            n_eff = {1'b0, reload};
  end

  assign hi_len = (n_eff + ONE) >> 1;
  assign last   = ({1'b0, cnt} == (n_eff - ONE));
  assign term   = gate && tick && !pend && last;
  assign out    = gate && ({1'b0, cnt} < hi_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (!gate)                cnt <= '0;
      else if (tick) begin
        if (pend || last)       cnt <= '0;
        else                    cnt <= cnt + 1'b1;
      end
      if (load_stb)             pend <= 1'b1;
      else if (tick || !gate)   pend <= 1'b0;
    end
  end

  // R4: a gated-off counter keeps its output low
  p_gated_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> !out);
  // R3: count stays inside the decoded period unless a restart is pending
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> ({1'b0, cnt} < n_eff));
  // R7: a pending restart lands at the period start on the next tick
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && tick && pend && !load_stb) |=> (cnt == '0));
  // R3: terminal count wraps to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (cnt == '0));
endmodule

// File: rtl/pgt_route.sv
module pgt_route #(
  parameter int NG = 2
) (
  input  logic [NG-1:0] hs_sel,
  input  logic [NG-1:0] ctr_out,
  input  logic [NG-1:0] ext_req,
  output logic [NG-1:0] req
);
  for (genvar g = 0; g < NG; g++) begin : g_mux
    assign req[g] = hs_sel[g] ? ctr_out[g] : ext_req[g];
  end
endmodule

// File: rtl/pgt_top.sv
module pgt_top
  import pgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [NUM_GRP-1:0] ext_en,
  input  logic [NUM_GRP-1:0] ext_req,
  output logic [NUM_GRP-1:0] req,
  output logic              irq
);
  logic [NUM_DIV-1:0][CNT_W-1:0] reload_q;
  logic [NUM_DIV-1:0]            load_stb;
  logic [CFG_W-1:0]              cfg_q;
  logic [NUM_DIV-1:0]            div_tick;
  logic [NUM_DIV-1:0]            div_gate;
  logic [NUM_DIV-1:0]            div_out;
  logic [NUM_DIV-1:0]            div_term;
  logic                          pre_stb_q;
  logic [NUM_GRP-1:0]            hs_sel;

  pgt_regs #(.CW(CNT_W), .AW(ADDR_W), .ND(NUM_DIV), .CFGW(CFG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .reload_q (reload_q),
    .load_stb (load_stb),
    .cfg_q    (cfg_q)
  );

  // Divider 0 is the free-running prescaler; 1..NUM_GRP pace the groups.
  assign div_tick[0] = base_tick;
  assign div_gate[0] = 1'b1;
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign div_tick[g+1] = cfg_q[CFG_SRC_LSB+g] ? pre_stb_q : base_tick;
    assign div_gate[g+1] = cfg_q[CFG_EN_LSB+g] && ext_en[g];
    assign hs_sel[g]     = cfg_q[CFG_HS_LSB+g];

    // R3: after a wrap the request counter starts its high phase
    p_req_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
      div_term[g+1] |=> (div_out[g+1] || !div_gate[g+1]));
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    pgt_divider #(.CW(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (div_tick[i]),
      .gate     (div_gate[i]),
      .load_stb (load_stb[i]),
      .reload   (reload_q[i]),
      .out      (div_out[i]),
      .term     (div_term[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pre_stb_q <= 1'b0;
    else        pre_stb_q <= div_term[0];
  end
  assign irq = pre_stb_q;

  pgt_route #(.NG(NUM_GRP)) u_route (
    .hs_sel  (hs_sel),
    .ctr_out (div_out[NUM_DIV-1:1]),
    .ext_req (ext_req),
    .req     (req)
  );

  // R1: the interrupt is a single-cycle pulse
  p_irq_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: tb/pgt_top_tb.sv
module pgt_top_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic base_tick = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [1:0] ext_en = 0;
  logic [1:0] ext_req = 0;
  logic [1:0] req;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  pgt_top u_dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ext_en(ext_en),
    .ext_req(ext_req), .req(req), .irq(irq)
  );

  // ---------------- reference model from the requirements ----------------
  logic [15:0] m_rel [3];
  int          m_cnt [3];
  bit          m_pend [3];
  logic [5:0]  m_cfg;
  bit          m_pstb;

  function automatic int neff(logic [15:0] v);
    if (v == 0) return 65536;
    if (v == 1) return 2;
    return int'(v);
  endfunction

  function automatic bit m_gate(int i);
    if (i == 0) return 1'b1;
    return m_cfg[i-1] && ext_en[i-1];
  endfunction

  function automatic bit m_out(int i);
    return m_gate(i) && (m_cnt[i] < (neff(m_rel[i]) + 1) / 2);
  endfunction

  function automatic bit m_req(int g);
    return m_cfg[2+g] ? m_out(g+1) : ext_req[g];
  endfunction

  always @(posedge clk) begin
    bit g_v, tk_v, last_v, ld_v, trm0;
    int nc [3];
    bit np [3];
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_rel[i] = 0; m_cnt[i] = 0; m_pend[i] = 0;
      end
      m_cfg = 0; m_pstb = 0;
    end else begin
      trm0 = 0;
      for (int i = 0; i < 3; i++) begin
        g_v  = m_gate(i);
        tk_v = (i == 0) ? base_tick : (m_cfg[3+i] ? m_pstb : base_tick);
        last_v = (m_cnt[i] == neff(m_rel[i]) - 1);
        ld_v = wr_en && (int'(wr_addr) == i);
        if (i == 0) trm0 = g_v && tk_v && !m_pend[i] && last_v;
        if (!g_v) nc[i] = 0;
        else if (tk_v) nc[i] = (m_pend[i] || last_v) ? 0 : m_cnt[i] + 1;
        else nc[i] = m_cnt[i];
        if (ld_v) np[i] = 1;
        else if (tk_v || !g_v) np[i] = 0;
        else np[i] = m_pend[i];
      end
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = nc[i]; m_pend[i] = np[i];
      end
      m_pstb = trm0;
      if (wr_en) begin
        if (wr_addr == 2'd3) m_cfg = wr_data[5:0];
        else m_rel[wr_addr] = wr_data;
      end
    end
  end

  // Continuous comparison against the model (R3, R4, R5, R6 on req; R1 on irq)
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      for (int g = 0; g < 2; g++) begin
        checks++;
        if (req[g] !== m_req(g)) begin
          failures++;
          $display("FAIL R3 R4 R5 R6 model req[%0d] actual=%0b expected=%0b t=%0t",
                   g, req[g], m_req(g), $time);
        end
      end
      checks++;
      if (irq !== m_pstb) begin
        failures++;
        $display("FAIL R1 model irq actual=%0b expected=%0b t=%0t", irq, m_pstb, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_wait();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    drive_wait();
    wr_en = 1; wr_addr = a; wr_data = d;
    drive_wait();
    wr_en = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive_wait();
  endtask

  // Sample req[g] at n+1 negedges: highs over the first n, rises over n transitions.
  task automatic sample_req(int g, int n, output int highs, output int rises);
    bit prev, cur;
    highs = 0; rises = 0;
    @(negedge clk); prev = req[g];
    for (int k = 0; k < n; k++) begin
      if (prev) highs++;
      @(negedge clk); cur = req[g];
      if (cur && !prev) rises++;
      prev = cur;
    end
  endtask

  task automatic irq_period(output int n);
    n = 0;
    do @(negedge clk); while (!irq);
    do begin @(negedge clk); n++; end while (!irq);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int h, r, p;
    void'($urandom(32'd4711));
    ext_req = 2'b10;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cmp_on = 1;

    // R9: reset state
    @(negedge clk);
    check("R9 irq after reset", irq, 0);
    check("R9 req follows ext_req after reset", req, 2'b10);

    // R8: cfg address 3, hs bits 2,3 set, enables clear -> counters gated -> low
    ext_req = 2'b11;
    wr(2'd3, 16'h000C);
    @(negedge clk);
    check("R8 R4 req gated low with hs set", req, 0);

    // R3: ctr1 N=5 on base tick: 12 highs in 20 cycles
    base_tick = 1; ext_en = 2'b11;
    wr(2'd1, 16'd5);
    wr(2'd3, 16'h0005);
    idle(8);
    sample_req(0, 20, h, r);
    check("R3 odd period high count", h, 12);
    check("R3 odd period rises", r, 4);

    // R2: reload 1 acts as 2
    wr(2'd1, 16'd1);
    idle(4);
    sample_req(0, 20, h, r);
    check("R2 reload one highs", h, 10);
    check("R2 reload one rises", r, 10);

    // R7: restart after reload write, new value 6 -> 1,1,1,0,0,0
    wr(2'd1, 16'd5);
    idle(6);
    wr(2'd1, 16'd6);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R7 restart pattern", req[0], (k < 3) ? 1 : 0);
    end

    // R1: prescaler period 5 with steady tick
    wr(2'd0, 16'd5);
    irq_period(p);
    check("R1 prescaler period 5", p, 5);

    // R5: ctr1 N=3 cascaded from prescaler N=2 -> period 6, then base -> period 3
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd3);
    wr(2'd3, 16'h0015);
    idle(12);
    sample_req(0, 24, h, r);
    check("R5 cascaded rises", r, 4);
    wr(2'd3, 16'h0005);
    idle(6);
    sample_req(0, 24, h, r);
    check("R5 base source rises", r, 8);

    // R4: external enable low, then config enable low
    ext_en = 2'b10;
    idle(2);
    sample_req(0, 20, h, r);
    check("R4 ext enable low", h, 0);
    ext_en = 2'b11;
    wr(2'd3, 16'h000C);
    idle(2);
    sample_req(1, 20, h, r);
    check("R4 cfg enable low", h, 0);

    // R6: hs bits clear -> pass-through
    wr(2'd3, 16'h0003);
    for (int k = 0; k < 4; k++) begin
      ext_req = 2'(k);
      @(negedge clk);
      check("R6 pass-through", req, k);
      drive_wait();
    end

    // Random traffic, checked against the model every cycle
    for (int k = 0; k < 3000; k++) begin
      base_tick = ($urandom % 3) == 0;
      if (($urandom % 16) == 0) ext_en = 2'($urandom);
      ext_req = 2'($urandom);
      if (($urandom % 20) == 0) begin
        wr_en = 1;
        wr_addr = 2'($urandom);
        wr_data = (wr_addr == 2'd3) ? 16'($urandom % 64) : 16'(1 + $urandom % 9);
      end else begin
        wr_en = 0;
      end
      drive_wait();
    end
    wr_en = 0;

    // R2: reload 0 means 65536
    base_tick = 1;
    wr(2'd0, 16'd0);
    irq_period(p);
    check("R2 reload zero period", p, 65536);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule